// File: doc/BRIEF.md
# Link Attention Interrupt Controller

This block is the control and status register for one end of a point-to-point parallel link between two processors. Software reads and writes a 16-bit CSR over a simple strobe interface. One CSR bit drives a function output pin that is wired to the attention input of the partner end. Software signals the partner by setting that bit and then clearing it again.

On the receiving end, each rising edge of the attention input raises an error/attention flag. When interrupt enable is set, that flag drives a level interrupt request. An edge that arrives while the flag is still set is not lost. It is counted in a pending counter, and the flag is raised again after software acknowledges the current one. Every remote pulse therefore produces exactly one interrupt, however late the service routine runs.

A maintenance bit holds the event logic in a local soft reset. A synchronous bus reset input returns the whole block to idle. Interrupt enable can be written in the same write that leaves maintenance mode, and it stays set.

Top module: `link_attn_ctrl`

## Requirements
- R1: After rst_ni low, or one cycle of bus_rst_i high, rdata_o reads 0x0000 and irq_o and fn_o are low.
- R2: CSR bit 0 is the function bit. fn_o follows the value last written to it while maintenance mode is off.
- R3: A rising edge of attn_i sets the error flag (CSR bit 15) within SYNC_STAGES+2 clock cycles.
- R4: irq_o is high exactly when the error flag and interrupt enable (CSR bit 6) are both set. It drops when either one is cleared.
- R5: A rising edge of attn_i that arrives while the error flag is set, or in the cycle it is acknowledged, increments the pending count. After an acknowledge, the flag is low for one cycle and is raised again once for each counted edge, so each attention edge yields exactly one rising edge of irq_o.
- R6: Writing 0x0040 sets interrupt enable, clears the function and maintenance bits, and leaves the error flag unchanged.
- R7: A write with bit 15 set selects the error view. While it is selected, rdata_o returns the pending count in bits [PEND_W-1:0] with all other bits zero. A rd_i strobe returns reads to the CSR.
- R8: While the maintenance bit (CSR bit 5) is set, the error flag and pending count are held clear, interrupt enable and the function bit read 0, and attention edges are ignored.
- R9: A write that clears maintenance and sets interrupt enable leaves interrupt enable set in that and every later cycle until software changes it. No settling delay is needed.
- R10: CSR bit 13 reads the synchronized level of attn_i.
- R11: An acknowledge (a write with bit 14 set) with no pending edges leaves the error flag clear. Bit 14 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_rst_i | input | 1 | Synchronous bus reset |
| wr_i | input | 1 | CSR write strobe |
| rd_i | input | 1 | Read strobe; ends the error view |
| wdata_i | input | 16 | CSR write data |
| rdata_o | output | 16 | CSR or error view read data |
| attn_i | input | 1 | Attention from the partner's function output |
| fn_o | output | 1 | Function output to the partner's attention input |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two instances are cross-coupled, so the partner's function bit drives the attention input of the instance under test. Directed pulses check single delivery, pulses stacked while the flag is set, acknowledge with and without pending edges, and the enable written while leaving maintenance mode. These separate a counter that drops or merges edges from one that redelivers them. A random phase then varies the spacing between toggles against a randomly delayed service routine. A scoreboard pairs each toggle with one rising edge of irq_o, which exposes lost, duplicated or spurious interrupts that fixed spacing would hide.

// File: rtl/link_attn_pkg.sv
package link_attn_pkg;
  localparam int unsigned CSR_W   = 16;
  localparam int unsigned B_FN    = 0;
  localparam int unsigned B_MAINT = 5;
  localparam int unsigned B_IE    = 6;
  localparam int unsigned B_ATTN  = 13;
  localparam int unsigned B_ACK   = 14;
  localparam int unsigned B_ERR   = 15;

  typedef struct packed {
    logic maint;
    logic ie;
    logic fn;
  } ctl_t;
endpackage

// File: rtl/attn_edge_sync.sv
module attn_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic attn_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= attn_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;

  p_rise_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/attn_event_track.sv
module attn_event_track #(
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              ack_i,
  output logic              err_o,
  output logic [PEND_W-1:0] pend_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              err_q;
  logic [PEND_W-1:0] pend_q;
  logic              room;

  assign room = (pend_q != PEND_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      pend_q <= '0;
    end else if (clr_i) begin
      err_q  <= 1'b0;
      pend_q <= '0;
    end else if (ack_i) begin
      // flag drops for a cycle so a level consumer sees a fresh edge
      err_q <= 1'b0;
      if (rise_i && room) pend_q <= pend_q + 1'b1;
    end else if (!err_q) begin
      if (rise_i) begin
        err_q <= 1'b1;
      end else if (pend_q != '0) begin
        err_q  <= 1'b1;
        pend_q <= pend_q - 1'b1;
      end
    end else if (rise_i && room) begin
      pend_q <= pend_q + 1'b1;
    end
  end

  assign err_o  = err_q;
  assign pend_o = pend_q;

  p_edge_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ack_i && !err_q && rise_i) |=> err_q);
  p_edge_counted_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ack_i && err_q && rise_i && room) |=> (pend_q == $past(pend_q) + 1'b1));
  p_redeliver_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ack_i && !err_q && pend_q != '0) |=> err_q);
  p_ack_drops_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !clr_i) |=> !err_q);
  p_hold_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!err_q && pend_q == '0));
endmodule

// File: rtl/link_csr_regs.sv
module link_csr_regs
  import link_attn_pkg::*;
#(
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CSR_W-1:0]  wdata_i,
  input  logic              err_i,
  input  logic              attn_lvl_i,
  input  logic [PEND_W-1:0] pend_i,
  output logic [CSR_W-1:0]  rdata_o,
  output logic              fn_o,
  output logic              ie_o,
  output logic              maint_o,
  output logic              ack_o
);
  ctl_t ctl_q;
  logic view_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      view_q <= 1'b0;
    end else if (bus_rst_i) begin
      ctl_q  <= '0;
      view_q <= 1'b0;
    end else if (wr_i) begin
      // enable lands with the same write that leaves maintenance
      ctl_q.maint <= wdata_i[B_MAINT];
      ctl_q.ie    <= wdata_i[B_IE] & ~wdata_i[B_MAINT];
      ctl_q.fn    <= wdata_i[B_FN] & ~wdata_i[B_MAINT];
      view_q      <= wdata_i[B_ERR];
    end else if (rd_i) begin
      view_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (view_q) begin
      rdata_o[PEND_W-1:0] = pend_i;
    end else begin
      rdata_o[B_FN]    = ctl_q.fn;
      rdata_o[B_MAINT] = ctl_q.maint;
      rdata_o[B_IE]    = ctl_q.ie;
      rdata_o[B_ATTN]  = attn_lvl_i;
      rdata_o[B_ERR]   = err_i;
    end
  end

  assign fn_o    = ctl_q.fn;
  assign ie_o    = ctl_q.ie;
  assign maint_o = ctl_q.maint;
  assign ack_o   = wr_i & wdata_i[B_ACK] & ~bus_rst_i;

  p_ie_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.ie && !wr_i && !bus_rst_i) |=> ctl_q.ie);
  p_maint_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !bus_rst_i && wdata_i[B_IE] && !wdata_i[B_MAINT]) |=> ctl_q.ie);
  p_view_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> !view_q);
  p_maint_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.maint |-> (!ctl_q.ie && !ctl_q.fn));
  p_bus_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (ctl_q == '0 && !view_q));
endmodule

// File: rtl/link_attn_ctrl.sv
module link_attn_ctrl
  import link_attn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PEND_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_rst_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [CSR_W-1:0] wdata_i,
  output logic [CSR_W-1:0] rdata_o,
  input  logic             attn_i,
  output logic             fn_o,
  output logic             irq_o
);
  logic              attn_lvl, attn_rise;
  logic              err, ie, maint, ack, hold;
  logic [PEND_W-1:0] pend;

  attn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .attn_i  (attn_i),
    .level_o (attn_lvl),
    .rise_o  (attn_rise)
  );

  assign hold = bus_rst_i | maint;

  attn_event_track #(.PEND_W(PEND_W)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hold),
    .rise_i (attn_rise),
    .ack_i  (ack),
    .err_o  (err),
    .pend_o (pend)
  );

  link_csr_regs #(.PEND_W(PEND_W)) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_rst_i  (bus_rst_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .err_i      (err),
    .attn_lvl_i (attn_lvl),
    .pend_i     (pend),
    .rdata_o    (rdata_o),
    .fn_o       (fn_o),
    .ie_o       (ie),
    .maint_o    (maint),
    .ack_o      (ack)
  );

  assign irq_o = err & ie;

  p_irq_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack && !attn_rise) |=> !irq_o);
endmodule

// File: tb/link_attn_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_attn_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst = 1'b0;
  logic        d_wr = 1'b0, d_rd = 1'b0, p_wr = 1'b0, p_rd = 1'b0;
  logic [15:0] d_wdata = '0, p_wdata = '0;
  logic [15:0] d_rdata, p_rdata;
  logic        d_fn, p_fn, d_irq, p_irq;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int pushed = 0;
  int seen = 0;
  int pop_id;
  bit sb_on = 1'b0;
  bit isr_on = 1'b0;
  bit irq_prev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_attn_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst),
    .wr_i(d_wr), .rd_i(d_rd), .wdata_i(d_wdata), .rdata_o(d_rdata),
    .attn_i(p_fn), .fn_o(d_fn), .irq_o(d_irq)
  );

  link_attn_ctrl peer_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst),
    .wr_i(p_wr), .rd_i(p_rd), .wdata_i(p_wdata), .rdata_o(p_rdata),
    .attn_i(d_fn), .fn_o(p_fn), .irq_o(p_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic d_write(input logic [15:0] v);
    @(negedge clk); d_wdata = v; d_wr = 1'b1;
    @(negedge clk); d_wr = 1'b0;
  endtask

  task automatic p_write(input logic [15:0] v);
    @(negedge clk); p_wdata = v; p_wr = 1'b1;
    @(negedge clk); p_wr = 1'b0;
  endtask

  task automatic d_read_strobe();
    @(negedge clk); d_rd = 1'b1;
    @(negedge clk); d_rd = 1'b0;
  endtask

  task automatic p_pulse();
    p_write(16'h0001);
    repeat (3) @(negedge clk);
    p_write(16'h0000);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor: one irq rising edge per queued toggle
  initial begin
    forever begin
      @(negedge clk);
      if (sb_on && d_irq && !irq_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 spurious interrupt", 1, 0);
        end else begin
          pop_id = exp_q.pop_front();
          check(pop_id == seen, "R5 interrupt order", pop_id, seen);
          seen++;
        end
      end
      irq_prev = d_irq;
    end
  end

  // service routine with random latency
  initial begin
    forever begin
      @(negedge clk);
      if (isr_on && d_irq) begin
        repeat ($urandom_range(0, 50)) @(negedge clk);
        d_write(16'h4040);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(d_rdata == 16'h0000, "R1 reset csr", d_rdata, 16'h0000);
    check(d_irq == 1'b0 && d_fn == 1'b0, "R1 reset outputs", {d_irq, d_fn}, 0);

    d_write(16'h0001);
    check(d_fn == 1'b1, "R2 fn set", d_fn, 1);
    d_write(16'h0000);
    check(d_fn == 1'b0, "R2 fn clear", d_fn, 0);

    d_write(16'h0040);
    check(d_rdata == 16'h0040, "R6 enable write", d_rdata, 16'h0040);

    p_write(16'h0001);
    repeat (5) @(negedge clk);
    check(d_rdata == 16'hA040, "R3 R10 flag and level", d_rdata, 16'hA040);
    check(d_irq == 1'b1, "R4 irq with enable", d_irq, 1);
    p_write(16'h0000);
    repeat (5) @(negedge clk);
    check(d_rdata == 16'h8040, "R10 level low", d_rdata, 16'h8040);

    d_write(16'h0000);
    check(d_irq == 1'b0 && d_rdata == 16'h8000, "R4 enable off", d_rdata, 16'h8000);
    d_write(16'h0040);
    check(d_irq == 1'b1 && d_rdata == 16'h8040, "R6 enable keeps flag", d_rdata, 16'h8040);

    p_pulse();
    p_pulse();
    d_write(16'h8040);
    check(d_rdata == 16'h0002, "R7 error view pending", d_rdata, 16'h0002);
    d_read_strobe();
    check(d_rdata == 16'h8040, "R7 view released", d_rdata, 16'h8040);

    d_write(16'h4040);
    check(d_irq == 1'b0, "R5 flag gap after ack", d_irq, 0);
    @(negedge clk);
    check(d_irq == 1'b1, "R5 redelivered", d_irq, 1);
    d_write(16'h8040);
    check(d_rdata == 16'h0001, "R5 pending decremented", d_rdata, 16'h0001);
    d_read_strobe();
    d_write(16'h4040);
    repeat (2) @(negedge clk);
    check(d_irq == 1'b1, "R5 second redelivery", d_irq, 1);
    d_write(16'h4040);
    repeat (3) @(negedge clk);
    check(d_rdata == 16'h0040 && d_irq == 1'b0, "R11 ack without pending", d_rdata, 16'h0040);

    p_pulse();
    check(d_irq == 1'b1, "R3 flag before maint", d_irq, 1);
    d_write(16'h0061);
    repeat (2) @(negedge clk);
    check(d_rdata == 16'h0020, "R8 maint clears", d_rdata, 16'h0020);
    check(d_irq == 1'b0 && d_fn == 1'b0, "R8 maint outputs", {d_irq, d_fn}, 0);
    p_pulse();
    check(d_rdata == 16'h0020, "R8 edge ignored in maint", d_rdata, 16'h0020);
    d_write(16'h0040);
    check(d_rdata == 16'h0040, "R9 enable on maint exit", d_rdata, 16'h0040);
    repeat (30) @(negedge clk);
    check(d_rdata == 16'h0040 && d_irq == 1'b0, "R9 enable sticks", d_rdata, 16'h0040);

    p_pulse();
    check(d_rdata == 16'h8040, "R3 flag after maint", d_rdata, 16'h8040);
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    check(d_rdata == 16'h0000 && d_irq == 1'b0 && d_fn == 1'b0, "R1 bus reset", d_rdata, 0);

    // random phase: cross-coupled toggles against delayed service
    d_write(16'h0040);
    repeat (4) @(negedge clk);
    sb_on = 1'b1;
    isr_on = 1'b1;
    for (int i = 0; i < 150; i++) begin
      while (exp_q.size() >= 10) @(negedge clk);
      exp_q.push_back(pushed);
      pushed++;
      p_write(16'h0001);
      repeat (2 + $urandom_range(0, 3)) @(negedge clk);
      p_write(16'h0000);
      repeat ($urandom_range(2, 40)) @(negedge clk);
    end
    cnt = 0;
    while (exp_q.size() != 0 && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    repeat (80) @(negedge clk);
    isr_on = 1'b0;
    sb_on = 1'b0;
    check(exp_q.size() == 0, "R5 every toggle delivered", exp_q.size(), 0);
    check(seen == 150, "R5 interrupt count", seen, 150);
    check(d_rdata == 16'h0040 && d_irq == 1'b0, "R5 idle after service", d_rdata, 16'h0040);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule